// File: doc/BRIEF.md
# Flash Page Buffer Loader

This block collects one page of write data ahead of a NOR flash page-program operation. The command decoder hands it one write strobe per bus cycle after the page-program setup cycle, each strobe carrying an address and data. The block checks that the in-page address climbs by exactly one from zero on every write and that the page address never moves. It stores each item in a register array organised as 16-bit entries. Once the last location of the page is written, it raises a page-full flag, and the program engine then reads the page through a combinational read port.

Page geometry follows a byte/word mode input. In word mode a page is 128 entries of 16 bits, and the offset is word address bits 6..0. In byte mode a page is 256 bytes, and the offset is `{wr_addr[6:0], wr_lsb}`, where `wr_lsb` is the sub-word byte address bit. Pairs of bytes are packed into the same 16-bit entries. A write that breaks the order, or that names a different page, raises a sequence-error flag and abandons the load. An abort input, driven by reset or powerdown handling, clears the load state so that a new load can start.

Top module: `pgbuf_loader`

## Requirements
- R1: After reset `page_full` = 0, `seq_err` = 0 and `page_base` = 0.
- R2: In word mode (`byte_mode` = 0) an accepted write stores all 16 bits of `wr_data` in entry `wr_addr[6:0]`, and `wr_lsb` is ignored.
- R3: In byte mode (`byte_mode` = 1) an accepted write stores `wr_data[7:0]` in entry `wr_addr[6:0]`. It goes in bits 7:0 when `wr_lsb` = 0 and in bits 15:8 when `wr_lsb` = 1, and the other half of the entry is left as it was.
- R4: `page_base` takes `wr_addr[18:7]` from the first write of a load and holds it for the rest of the load and while the page is full.
- R5: `page_full` rises in the cycle after the write at the final offset (127 in word mode, 255 in byte mode) and stays 0 before that write.
- R6: A write whose offset differs from the expected one sets `seq_err` in the next cycle and stores nothing. The expected offset starts at 0 and then steps by one. `page_full` stays 0 and the load is abandoned.
- R7: A write after the first one whose `wr_addr[18:7]` differs from `page_base` sets `seq_err` and stores nothing.
- R8: While `page_full` or `seq_err` is 1, writes change neither the buffer nor the flags nor `page_base`.
- R9: `abort` clears the load position, `page_full` and `seq_err` at the next clock edge. It overrides a write in the same cycle, and the next write is then expected at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | Abandon the load and clear the flags |
| byte_mode | input | 1 | 1 = byte-wide page of 256 bytes, 0 = word-wide page of 128 words |
| wr_en | input | 1 | Data write strobe from the command decoder |
| wr_lsb | input | 1 | Byte-select address bit, used in byte mode only |
| wr_addr | input | 19 | Word address; bits 18:7 page, bits 6:0 offset |
| wr_data | input | 16 | Write data; only bits 7:0 are used in byte mode |
| rd_idx | input | 7 | Buffer entry read by the program engine |
| rd_data | output | 16 | Buffer entry contents, combinational |
| page_base | output | 12 | Page address captured from the load |
| page_full | output | 1 | Whole page loaded and ready to program |
| seq_err | output | 1 | Load abandoned on an out-of-order or wrong-page write |

## Verification
The assertions assume that `byte_mode` holds steady while a load is part-way through. The stimulus therefore changes it only after an abort, a sequence error or a completed page, when the load position is back at zero. They also assume that `wr_addr`, `wr_lsb` and `wr_data` are known whenever `wr_en` is high. The bench drives all of these from tasks at the falling edge and returns `wr_en` to 0 between bursts. It reads the buffer only at entries it has written since reset.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef enum logic {
    PG_WORD = 1'b0,
    PG_BYTE = 1'b1
  } pg_mode_e;

  // Lanes written by one accepted write: both in word mode, the one
  // chosen by the byte-select bit in byte mode (even byte = low lane).
  function automatic logic [LANES-1:0] lane_mask(input pg_mode_e mode, input logic lsb);
    logic [LANES-1:0] m;
    if (mode == PG_WORD) m = '1;
    else                 m = lsb ? 2'b10 : 2'b01;
    return m;
  endfunction
endpackage

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int PAGE_BITS = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        abort,
  input  pg_mode_e                    mode,
  input  logic                        wr_en,
  input  logic                        wr_lsb,
  input  logic [ADDR_W-1:0]           wr_addr,
  output logic                        wr_accept,
  output logic                        wr_bad,
  output logic                        load_done,
  output logic [PAGE_BITS:0]          load_cnt,
  output logic [ADDR_W-PAGE_BITS-1:0] page_base,
  output logic                        page_full,
  output logic                        seq_err
);
  localparam int OFF_W  = PAGE_BITS + 1;
  localparam int BASE_W = ADDR_W - PAGE_BITS;

  function automatic logic [OFF_W-1:0] in_page_off(input pg_mode_e m,
                                                   input logic [PAGE_BITS-1:0] lo,
                                                   input logic lsb);
    return (m == PG_BYTE) ? {lo, lsb} : {1'b0, lo};
  endfunction

  function automatic logic [OFF_W-1:0] last_off(input pg_mode_e m);
    return (m == PG_BYTE) ? {OFF_W{1'b1}} : {1'b0, {PAGE_BITS{1'b1}}};
  endfunction

  logic [OFF_W-1:0]  act_off;
  logic [BASE_W-1:0] act_base;
  logic              loading;
  logic              live;
  logic              in_order;

  assign act_off   = in_page_off(mode, wr_addr[PAGE_BITS-1:0], wr_lsb);
  assign act_base  = wr_addr[ADDR_W-1:PAGE_BITS];
  assign loading   = (load_cnt != '0);
  assign live      = wr_en && !abort && !page_full && !seq_err;
  assign in_order  = (act_off == load_cnt) && (!loading || act_base == page_base);
  assign wr_accept = live && in_order;
  assign wr_bad    = live && !in_order;
  assign load_done = wr_accept && (load_cnt == last_off(mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_cnt  <= '0;
      page_base <= '0;
      page_full <= 1'b0;
      seq_err   <= 1'b0;
    end else if (abort) begin
      load_cnt  <= '0;
      page_full <= 1'b0;
      seq_err   <= 1'b0;
    end else if (wr_bad) begin
      load_cnt  <= '0;
      seq_err   <= 1'b1;
    end else if (wr_accept) begin
      if (!loading) page_base <= act_base;
      if (load_done) begin
        load_cnt  <= '0;
        page_full <= 1'b1;
      end else begin
        load_cnt  <= load_cnt + 1'b1;
      end
    end
  end

  // R5: the final location makes the page full and rewinds the position
  a_r5_full_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> page_full && load_cnt == '0);

  // R5: page_full never rises without a completing write
  a_r5_no_early_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_full) |-> $past(load_done));

  // R6 / R7: a broken sequence flags an error and never a full page
  a_r6_err_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> seq_err && !page_full && load_cnt == '0);

  // R2 / R3: each accepted mid-page write advances the position by one
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && !load_done |=> load_cnt == $past(load_cnt) + 1'b1);

  // R4: the page address is frozen once a load is under way
  a_r4_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    loading && !abort |=> $stable(page_base));

  // R8: a stopped load ignores writes
  a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (page_full || seq_err) && !abort |=> $stable(page_full) && $stable(seq_err) && $stable(page_base));

  // R9: abort returns the loader to its idle state
  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !page_full && !seq_err && load_cnt == '0);

  // R3: input assumption, page geometry does not switch mid-load
  a_r3_mode_steady: assert property (@(posedge clk) disable iff (!rst_n)
    loading && !abort |-> $stable(mode));

  // R1: the two flags are never set together
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_full && seq_err));
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store
  import pgbuf_pkg::*;
#(
  parameter int PAGE_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  pg_mode_e             mode,
  input  logic [PAGE_BITS:0]   off,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [PAGE_BITS-1:0] rd_idx,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int DEPTH = 1 << PAGE_BITS;

  logic [PAGE_BITS-1:0] wr_idx;
  logic [LANES-1:0]     lane_we;

  assign wr_idx  = (mode == PG_BYTE) ? off[PAGE_BITS:1] : off[PAGE_BITS-1:0];
  assign lane_we = we ? lane_mask(mode, off[0]) : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_d;

    assign lane_d = (mode == PG_BYTE) ? wdata[LANE_W-1:0] : wdata[l*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (lane_we[l]) mem[wr_idx] <= lane_d;
    end

    assign rd_data[l*LANE_W +: LANE_W] = mem[rd_idx];
  end

  // R3: a byte write touches exactly one lane, a word write both
  a_r3_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> $countones(lane_we) == ((mode == PG_BYTE) ? 1 : LANES));
endmodule

// File: rtl/pgbuf_loader.sv
module pgbuf_loader
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int PAGE_BITS = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        abort,
  input  logic                        byte_mode,
  input  logic                        wr_en,
  input  logic                        wr_lsb,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [15:0]                 wr_data,
  input  logic [PAGE_BITS-1:0]        rd_idx,
  output logic [15:0]                 rd_data,
  output logic [ADDR_W-PAGE_BITS-1:0] page_base,
  output logic                        page_full,
  output logic                        seq_err
);
  pg_mode_e             mode;
  logic                 wr_accept;
  logic                 wr_bad;
  logic                 load_done;
  logic [PAGE_BITS:0]   load_cnt;

  assign mode = pg_mode_e'(byte_mode);

  pgbuf_seq #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .mode      (mode),
    .wr_en     (wr_en),
    .wr_lsb    (wr_lsb),
    .wr_addr   (wr_addr),
    .wr_accept (wr_accept),
    .wr_bad    (wr_bad),
    .load_done (load_done),
    .load_cnt  (load_cnt),
    .page_base (page_base),
    .page_full (page_full),
    .seq_err   (seq_err)
  );

  pgbuf_store #(.PAGE_BITS(PAGE_BITS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_accept),
    .mode    (mode),
    .off     (load_cnt),
    .wdata   (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  // R6: nothing is stored on the cycle a write is rejected
  a_r6_no_store_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |-> !wr_accept);

  // R9: a same-cycle abort wins over a write
  a_r9_abort_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !wr_accept && !wr_bad);

  // R8: a rejected or ignored write cannot complete a page
  a_r8_no_done_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (page_full || seq_err) |-> !load_done);
endmodule

// File: tb/sim_pgbuf_loader.sv
`timescale 1ns/100ps
module sim_pgbuf_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        abort = 1'b0;
  logic        byte_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_lsb = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [6:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic [11:0] page_base;
  logic        page_full;
  logic        seq_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_mem [128];

  always #2.5 clk = ~clk;

  pgbuf_loader u0 (
    .clk(clk), .rst_n(rst_n), .abort(abort), .byte_mode(byte_mode),
    .wr_en(wr_en), .wr_lsb(wr_lsb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .page_base(page_base),
    .page_full(page_full), .seq_err(seq_err)
  );

  // vector: {mode[28], base[27:16], seed[15:0]}
  localparam logic [28:0] VEC [4] = '{
    {1'b0, 12'h3A5, 16'h1234},
    {1'b1, 12'h0F0, 16'h0055},
    {1'b0, 12'hFFF, 16'hBEEF},
    {1'b1, 12'h001, 16'h00C3}
  };

  function automatic logic [15:0] wdat(input logic [15:0] seed, input int i);
    return seed + 16'(i) * 16'h0103;
  endfunction

  function automatic logic [7:0] bdat(input logic [15:0] seed, input int i);
    return seed[7:0] + 8'(i);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic mode, input logic [11:0] base, input int off, input logic [15:0] data);
    @(negedge clk);
    byte_mode = mode;
    wr_en     = 1'b1;
    wr_data   = data;
    if (mode) begin
      wr_addr = {base, 7'(off >> 1)};
      wr_lsb  = off[0];
    end else begin
      wr_addr = {base, 7'(off)};
      wr_lsb  = ~off[0];   // ignored in word mode
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0;
    abort = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk);
    wr_en = 1'b0;
    abort = 1'b1;
    idle();
  endtask

  // in-order load of n items starting at offset 0; model updated as accepted
  task automatic load_page(input logic mode, input logic [11:0] base, input logic [15:0] seed, input int n);
    for (int i = 0; i < n; i++) begin
      if (mode) begin
        wr(mode, base, i, {8'h5A, bdat(seed, i)});
        if (i[0]) exp_mem[i >> 1][15:8] = bdat(seed, i);
        else      exp_mem[i >> 1][7:0]  = bdat(seed, i);
      end else begin
        wr(mode, base, i, wdat(seed, i));
        exp_mem[i] = wdat(seed, i);
      end
    end
    idle();
  endtask

  task automatic check_mem(input string req);
    int bad = 0;
    logic [15:0] first_act = '0;
    logic [15:0] first_exp = '0;
    for (int j = 0; j < 128; j++) begin
      rd_idx = 7'(j);
      #0.5;
      if (rd_data !== exp_mem[j]) begin
        if (bad == 0) begin
          first_act = rd_data;
          first_exp = exp_mem[j];
        end
        bad++;
      end
    end
    check({req, " buffer mismatches"}, 32'(bad), 32'd0);
    if (bad != 0) check({req, " first bad entry"}, {16'h0, first_act}, {16'h0, first_exp});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 128; j++) exp_mem[j] = 16'h0000;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 page_full", {31'h0, page_full}, 32'd0);
    check("R1 seq_err", {31'h0, seq_err}, 32'd0);
    check("R1 page_base", {20'h0, page_base}, 32'd0);
    rst_n = 1'b1;
    idle();

    // table of full-page loads
    for (int v = 0; v < 4; v++) begin
      do_abort();
      check("R9 full cleared", {31'h0, page_full}, 32'd0);
      load_page(VEC[v][28], VEC[v][27:16], VEC[v][15:0], VEC[v][28] ? 256 : 128);
      check("R5 page_full after last", {31'h0, page_full}, 32'd1);
      check("R6 no error on ordered load", {31'h0, seq_err}, 32'd0);
      check("R4 page_base", {20'h0, page_base}, {20'h0, VEC[v][27:16]});
      check_mem(VEC[v][28] ? "R3 byte page" : "R2 word page");
    end

    // R8: page full, a further write is ignored
    wr(1'b0, 12'h777, 0, 16'hAAAA);
    idle();
    check("R8 full held", {31'h0, page_full}, 32'd1);
    check("R8 no error", {31'h0, seq_err}, 32'd0);
    check("R8 base held", {20'h0, page_base}, 32'h001);
    check_mem("R8 full buffer");

    // R5 boundary: not full after 127 words, full after 128
    do_abort();
    load_page(1'b0, 12'h100, 16'h0F0F, 127);
    check("R5 not full at 127", {31'h0, page_full}, 32'd0);
    wr(1'b0, 12'h100, 127, wdat(16'h0F0F, 127));
    exp_mem[127] = wdat(16'h0F0F, 127);
    idle();
    check("R5 full at 128", {31'h0, page_full}, 32'd1);
    check_mem("R2 boundary page");

    // R5 byte boundary: not full after 255 bytes
    do_abort();
    load_page(1'b1, 12'h101, 16'h0033, 255);
    check("R5 byte not full at 255", {31'h0, page_full}, 32'd0);
    wr(1'b1, 12'h101, 255, {8'h00, bdat(16'h0033, 255)});
    exp_mem[127][15:8] = bdat(16'h0033, 255);
    idle();
    check("R5 byte full at 256", {31'h0, page_full}, 32'd1);

    // R6: out-of-order write
    do_abort();
    load_page(1'b0, 12'h222, 16'h7777, 5);
    wr(1'b0, 12'h222, 9, 16'hDEAD);
    idle();
    check("R6 seq_err on skip", {31'h0, seq_err}, 32'd1);
    check("R6 not full", {31'h0, page_full}, 32'd0);
    check_mem("R6 skipped entry untouched");
    // R8: stopped on error, the correct next write is ignored
    wr(1'b0, 12'h222, 5, 16'h5555);
    idle();
    check("R8 error held", {31'h0, seq_err}, 32'd1);
    check_mem("R8 error buffer");

    // R6: first write not at offset 0
    do_abort();
    check("R9 error cleared", {31'h0, seq_err}, 32'd0);
    wr(1'b0, 12'h010, 1, 16'h1111);
    idle();
    check("R6 nonzero first offset", {31'h0, seq_err}, 32'd1);
    check_mem("R6 first write not stored");

    // R7: page address changes mid-load
    do_abort();
    load_page(1'b1, 12'h333, 16'h0011, 4);
    wr(1'b1, 12'h334, 4, 16'h00EE);
    idle();
    check("R7 seq_err on page change", {31'h0, seq_err}, 32'd1);
    check("R7 base kept", {20'h0, page_base}, 32'h333);
    check_mem("R7 rejected byte not stored");

    // R9: abort mid-load, then abort together with a write
    do_abort();
    load_page(1'b0, 12'h444, 16'h1357, 10);
    do_abort();
    check("R9 no error after abort", {31'h0, seq_err}, 32'd0);
    check("R9 not full after abort", {31'h0, page_full}, 32'd0);
    @(negedge clk);
    abort = 1'b1;
    byte_mode = 1'b0;
    wr_en = 1'b1;
    wr_addr = {12'h555, 7'd0};
    wr_data = 16'hFFFF;
    idle();
    load_page(1'b0, 12'h666, 16'h2468, 128);
    check("R9 restart from offset 0", {31'h0, seq_err}, 32'd0);
    check("R9 restarted page full", {31'h0, page_full}, 32'd1);
    check("R9 restart base", {20'h0, page_base}, 32'h666);
    check_mem("R9 restarted page");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule